// File: doc/BRIEF.md
# SPI Burst Memory Access Master

This engine copies a run of bytes between a local byte-addressed buffer and the memory of a remote device that sits behind an SPI link. A request carries a 32-bit remote start address, a byte count and a direction flag. The engine breaks the request into SPI transactions. Each transaction is one chip-select window: a command byte, the chunk's remote address sent most significant byte first, and then the data body. Byte `n` of the request always lives at local buffer offset `n`.

For each chunk the engine chooses between a single 4-byte access and a burst. It picks the burst length from the bytes still to move. Body bytes on the wire are mirrored inside each word of up to eight bytes. Requests that break the alignment rules are refused with a sticky error flag. The SPI side runs in mode 0, most significant bit first, with a fixed clock divider.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, cs_no is high, and sclk_o, busy_o, done_o and err_o are all low.
- R2: Every transaction begins with five bytes: the command byte, then the 32-bit chunk address from bit 31 down to bit 0. Bits are shifted MSB first in SPI mode 0: MOSI changes only while SCLK is low, and MISO is sampled on the rising edge.
- R3: A chunk is a single 4-byte access when its address mod 8 is 4 or when at most 4 bytes remain. It uses command 0x02 for a read and 0x03 for a write. Any other chunk is a burst, with command 0x04 for a read and 0x05 for a write.
- R4: A burst body is the remaining byte count rounded up to a multiple of 8, limited to MAX_BURST bytes (240 by default).
- R5: Let s be min(L, 8) for a body of L bytes. Body byte w+i (with w a multiple of s and i < s) corresponds to local offset chunk_offset + w + s-1-i.
- R6: A write transaction is 5 + L + 1 bytes long and its final byte is 0x00. A write body byte whose local offset is at or beyond the request length is sent as 0x00.
- R7: A read transaction sends the five header bytes, then four 0x00 bytes, then captures L body bytes (9 + L bytes in all). Captured bytes whose local offset is at or beyond the request length are not written to the buffer.
- R8: After each transaction the chunk address advances by L, wrapping modulo 2^32. Transactions repeat until the request length is covered. A zero-length request finishes with no transaction.
- R9: A read with addr[1:0] or len[1:0] non-zero is refused, and so is a write with addr[1:0] non-zero. A refused request starts no transaction, pulses done_o with err_o high, and err_o stays high until the next accepted start.
- R10: cs_no stays low for a whole transaction. It stays high for at least 2 SCLK periods between transactions, and SCLK is low whenever cs_no is high.
- R11: done_o is a one-cycle pulse after the last transaction. A start_i while busy_o is high is ignored. buf_re_o and buf_we_o are never high together, and read data returns one cycle after buf_re_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only while idle |
| write_i | input | 1 | 1 = local to remote, 0 = remote to local |
| addr_i | input | 32 | Remote start address |
| len_i | input | LEN_W | Request length in bytes |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Alignment refusal, held until next start |
| buf_addr_o | output | LEN_W | Local buffer byte offset |
| buf_re_o | output | 1 | Local buffer read enable |
| buf_we_o | output | 1 | Local buffer write enable |
| buf_wdata_o | output | 8 | Local buffer write data |
| buf_rdata_i | input | 8 | Local buffer read data, one cycle after buf_re_o |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
The bench aims at the corner cases of chunk selection:
- An address that is 4 mod 8 must force a single access. A design that skipped this would send a burst header at that address.
- A short tail must round up to a multiple of 8 with zero fill. Getting this wrong shows up as a short body or as stale bytes on MOSI.
- A 260-byte read must split at the 240-byte cap. Missing the cap produces one oversized transaction.
- A read whose burst overshoots the request must leave sentinel bytes in the buffer untouched past the request length.
- A chunk address that wraps past 0xFFFFFFFC must carry into a header of zero.

Refused requests must show no chip-select activity and a sticky error. A start strobe during a busy request must leave the transaction log unchanged.

// File: rtl/spi_burst_master_pkg.sv
package spi_burst_master_pkg;
  localparam logic [7:0] CMD_RD_WORD  = 8'h02;
  localparam logic [7:0] CMD_RD_BURST = 8'h04;
  localparam int unsigned HDR_BYTES   = 5;
  localparam int unsigned RD_PAD      = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PLAN, ST_LOAD, ST_SEND, ST_WAIT, ST_GAP
  } eng_st_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int unsigned CW = $clog2(HALF) + 1;

  logic          act_q, sclk_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !act_q) begin
        act_q <= 1'b1;
        cnt_q <= '0;
        bit_q <= '0;
        tx_q  <= tx_i;
      end else if (act_q) begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
endmodule

// File: rtl/spi_chunk_plan.sv
module spi_chunk_plan
  import spi_burst_master_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_BURST = 240,
  parameter int unsigned CL_W      = 8
) (
  input  logic [2:0]      alo_i,
  input  logic [LEN_W:0]  rem_i,
  input  logic            wr_i,
  output logic [7:0]      cmd_o,
  output logic [CL_W-1:0] clen_o
);
  logic [LEN_W+1:0] sum, up8;
  logic             single;

  always_comb begin
    sum    = {1'b0, rem_i} + (LEN_W+2)'(7);
    up8    = sum & ~(LEN_W+2)'(7);
    single = (alo_i == 3'd4) || (rem_i <= (LEN_W+1)'(4));
    if (single) begin
      cmd_o  = CMD_RD_WORD;
      clen_o = CL_W'(4);
    end else begin
      cmd_o  = CMD_RD_BURST;
      clen_o = (up8 > (LEN_W+2)'(MAX_BURST)) ? CL_W'(MAX_BURST) : up8[CL_W-1:0];
    end
    cmd_o = cmd_o + {7'd0, wr_i};
  end
endmodule

// File: rtl/spi_body_map.sv
module spi_body_map
  import spi_burst_master_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CL_W  = 8,
  parameter int unsigned KW    = 8
) (
  input  logic [KW-1:0]   k_i,
  input  logic [CL_W-1:0] clen_i,
  input  logic            wr_i,
  input  logic [LEN_W:0]  rem_i,
  output logic            is_body_o,
  output logic            in_rng_o,
  output logic [CL_W-1:0] idx_rel_o,
  output logic            last_o
);
  logic [KW-1:0]   bs, j, tot;
  logic [CL_W-1:0] m;

  always_comb begin
    bs        = wr_i ? KW'(HDR_BYTES) : KW'(HDR_BYTES + RD_PAD);
    j         = k_i - bs;
    is_body_o = (k_i >= bs) && (j < KW'(clen_i));
    // mirror within word: w + s-1-i == j ^ (s-1) for s in {4,8}
    m         = (clen_i == CL_W'(4)) ? CL_W'(3) : CL_W'(7);
    idx_rel_o = j[CL_W-1:0] ^ m;
    in_rng_o  = (LEN_W+1)'(idx_rel_o) < rem_i;
    tot       = KW'(clen_i) + (wr_i ? KW'(HDR_BYTES + 1) : KW'(HDR_BYTES + RD_PAD));
    last_o    = (k_i == tot - KW'(1));
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_master_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_BURST = 240,
  parameter int unsigned SCK_HALF  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [LEN_W-1:0] buf_addr_o,
  output logic             buf_re_o,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int unsigned CL_W    = $clog2(MAX_BURST + 1);
  localparam int unsigned KW      = $clog2(MAX_BURST + HDR_BYTES + RD_PAD + 1);
  localparam int unsigned GAP_CYC = 4 * SCK_HALF;
  localparam int unsigned GW      = $clog2(GAP_CYC + 1);

  eng_st_e          st_q;
  logic [31:0]      base_q;
  logic [LEN_W-1:0] len_q;
  logic             wr_q, cs_n_q, done_q, err_q;
  logic [LEN_W:0]   off_q;
  logic [7:0]       cmd_q;
  logic [CL_W-1:0]  clen_q;
  logic [KW-1:0]    k_q;
  logic [GW-1:0]    gap_q;

  logic [31:0]      caddr;
  logic [LEN_W:0]   rem;
  logic [7:0]       pl_cmd, tx_byte, sh_rx;
  logic [CL_W-1:0]  pl_clen, idx_rel;
  logic             is_body, in_rng, last, sh_done, bad;

  assign caddr = base_q + 32'(off_q);
  assign rem   = {1'b0, len_q} - off_q;
  assign bad   = write_i ? (|addr_i[1:0]) : ((|addr_i[1:0]) || (|len_i[1:0]));

  spi_chunk_plan #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .CL_W(CL_W)) u_plan (
    .alo_i (caddr[2:0]),
    .rem_i (rem),
    .wr_i  (wr_q),
    .cmd_o (pl_cmd),
    .clen_o(pl_clen)
  );

  spi_body_map #(.LEN_W(LEN_W), .CL_W(CL_W), .KW(KW)) u_map (
    .k_i      (k_q),
    .clen_i   (clen_q),
    .wr_i     (wr_q),
    .rem_i    (rem),
    .is_body_o(is_body),
    .in_rng_o (in_rng),
    .idx_rel_o(idx_rel),
    .last_o   (last)
  );

  always_comb begin
    tx_byte = 8'h00;
    if (k_q == KW'(0))      tx_byte = cmd_q;
    else if (k_q == KW'(1)) tx_byte = caddr[31:24];
    else if (k_q == KW'(2)) tx_byte = caddr[23:16];
    else if (k_q == KW'(3)) tx_byte = caddr[15:8];
    else if (k_q == KW'(4)) tx_byte = caddr[7:0];
    else if (wr_q && is_body && in_rng) tx_byte = buf_rdata_i;
  end

  spi_byte_shifter #(.HALF(SCK_HALF)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(st_q == ST_SEND),
    .tx_i   (tx_byte),
    .done_o (sh_done),
    .rx_o   (sh_rx),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .miso_i (miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      len_q  <= '0;
      wr_q   <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      off_q  <= '0;
      cmd_q  <= '0;
      clen_q <= '0;
      k_q    <= '0;
      gap_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          base_q <= addr_i;
          len_q  <= len_i;
          wr_q   <= write_i;
          off_q  <= '0;
          err_q  <= bad;
          if (bad || len_i == '0) done_q <= 1'b1;
          else                    st_q   <= ST_PLAN;
        end
        ST_PLAN: begin
          cmd_q  <= pl_cmd;
          clen_q <= pl_clen;
          k_q    <= '0;
          cs_n_q <= 1'b0;
          st_q   <= ST_LOAD;
        end
        ST_LOAD: st_q <= ST_SEND;
        ST_SEND: st_q <= ST_WAIT;
        ST_WAIT: if (sh_done) begin
          if (last) begin
            cs_n_q <= 1'b1;
            off_q  <= off_q + (LEN_W+1)'(clen_q);
            gap_q  <= '0;
            st_q   <= ST_GAP;
          end else begin
            k_q  <= k_q + KW'(1);
            st_q <= ST_LOAD;
          end
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) begin
            if (off_q >= {1'b0, len_q}) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_PLAN;
            end
          end else begin
            gap_q <= gap_q + GW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign cs_no       = cs_n_q;
  assign buf_addr_o  = off_q[LEN_W-1:0] + LEN_W'(idx_rel);
  assign buf_re_o    = (st_q == ST_LOAD) && wr_q && is_body && in_rng;
  assign buf_we_o    = (st_q == ST_WAIT) && sh_done && !wr_q && is_body && in_rng;
  assign buf_wdata_o = sh_rx;
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int unsigned GAP_MIN = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic buf_re_o,
  input logic buf_we_o,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o
);
  logic [7:0] hi_cnt;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      seen_q <= 1'b0;
    end else begin
      if (!cs_no)                hi_cnt <= '0;
      else if (hi_cnt != 8'hFF)  hi_cnt <= hi_cnt + 8'd1;
      if ($rose(cs_no))          seen_q <= 1'b1;
    end
  end

  a_r1_idle_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  a_r10_sclk_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r10_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && seen_q) |-> (hi_cnt >= 8'(GAP_MIN)));
  a_r2_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_buf_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_re_o && buf_we_o));
  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);
endmodule

bind spi_burst_master spi_burst_master_chk #(.GAP_MIN(4 * SCK_HALF)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .buf_re_o(buf_re_o),
  .buf_we_o(buf_we_o),
  .sclk_o  (sclk_o),
  .cs_no   (cs_no),
  .mosi_o  (mosi_o)
);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb;
  localparam int LEN_W = 16;
  localparam int HALF  = 2;
  localparam int GAP   = 4 * HALF;
  localparam int WD    = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, wr = 0;
  logic [31:0] addr = 0;
  logic [LEN_W-1:0] len = 0;
  logic busy, done, err, buf_re, buf_we, sclk, cs_n, mosi, miso = 0;
  logic [LEN_W-1:0] buf_addr;
  logic [7:0] buf_wdata, buf_rdata = 0;

  spi_burst_master #(.LEN_W(LEN_W), .MAX_BURST(240), .SCK_HALF(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr), .addr_i(addr),
    .len_i(len), .busy_o(busy), .done_o(done), .err_o(err), .buf_addr_o(buf_addr),
    .buf_re_o(buf_re), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
    .buf_rdata_i(buf_rdata), .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  int errors = 0, checks = 0, cyc = 0, ndone = 0, gapviol = 0, sclkviol = 0, hicnt = 0;
  bit seen = 0, prev_cs = 1, timeout = 0;

  function automatic logic [7:0] pat(int i, logic [7:0] s);
    return 8'(i * 37) ^ s ^ 8'(i >> 3);
  endfunction
  function automatic logic [7:0] rb(logic [31:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'hA5;
  endfunction

  // local buffer model, one-cycle read latency
  logic [7:0] lbuf [0:511];
  logic [7:0] exp_buf [0:511];
  logic fill = 0;
  logic [7:0] salt = 0;
  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < 512; i++) lbuf[i] <= pat(i, salt);
    end else begin
      if (buf_re) buf_rdata <= lbuf[buf_addr[8:0]];
      if (buf_we) lbuf[buf_addr[8:0]] <= buf_wdata;
    end
  end

  // remote device model and wire log
  logic [7:0] wlog [0:8191];
  int tx_start [0:255];
  int tx_len [0:255];
  int ntx = 0, lp = 0, bitc = 0, bytec = 0;
  bit in_tx = 0;
  logic [7:0] inb = 0, outb = 0;

  function automatic logic [7:0] next_out(int k);
    logic [7:0] c;
    logic [31:0] a;
    int ts;
    ts = tx_start[ntx];
    if (k < 9) return 8'h00;
    c = wlog[ts];
    if (c != 8'h02 && c != 8'h04) return 8'h00;
    a = {wlog[ts+1], wlog[ts+2], wlog[ts+3], wlog[ts+4]};
    return rb(a + 32'(k - 9));
  endfunction

  always @(negedge cs_n) begin
    tx_start[ntx] = lp; bitc = 0; bytec = 0; outb = 0; miso = 0; in_tx = 1;
  end
  always @(posedge cs_n) if (in_tx) begin
    tx_len[ntx] = bytec; ntx = ntx + 1; in_tx = 0;
  end
  always @(posedge sclk) if (!cs_n) begin
    inb = {inb[6:0], mosi};
    bitc = bitc + 1;
    if (bitc == 8) begin
      if (lp < 8192) wlog[lp] = inb;
      lp = lp + 1; bytec = bytec + 1; bitc = 0;
    end
  end
  always @(negedge sclk) if (!cs_n) begin
    if (bitc == 0) outb = next_out(bytec);
    miso = outb[7 - bitc];
  end

  always @(negedge clk) begin
    cyc++;
    if (done) ndone++;
    if (cs_n) begin
      if (sclk) sclkviol++;
      if (!prev_cs) seen = 1;
      hicnt++;
    end else begin
      if (prev_cs && seen && hicnt < GAP) gapviol++;
      hicnt = 0;
    end
    prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic run_req(input logic [31:0] a, input int n, input bit w, input bit poke);
    int t0, d0, off, rem, L, ws, w0, ii, si, hdr, ts, t, bad_i;
    logic [31:0] ca;
    logic [7:0] cmd, eb;
    bit experr, ok;
    salt = 8'($urandom);
    @(negedge clk) fill = 1;
    @(negedge clk) fill = 0;
    for (int i = 0; i < 512; i++) exp_buf[i] = pat(i, salt);
    t0 = ntx; d0 = ndone;
    experr = w ? (a[1:0] != 0) : (a[1:0] != 0 || n[1:0] != 0);
    @(negedge clk); start = 1; addr = a; len = LEN_W'(n); wr = w;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(busy == 1'b1, "R11 busy before poke", longint'(busy), 1);
      start = 1; addr = a ^ 32'h100; len = 8; wr = !w;
      @(negedge clk); start = 0;
    end
    while (!done && cyc < WD) @(negedge clk);
    if (cyc >= WD) timeout = 1;
    repeat (3) @(negedge clk);
    chk(ndone - d0 == 1, "R11 done pulse count", ndone - d0, 1);
    chk(err == experr, "R9 error flag", longint'(err), longint'(experr));
    if (experr) begin
      chk(ntx == t0, "R9 no transaction on refusal", ntx - t0, 0);
      repeat (10) @(negedge clk);
      chk(err == 1'b1, "R9 error held", longint'(err), 1);
      return;
    end
    off = 0; t = t0;
    while (off < n) begin
      ca = a + 32'(off); rem = n - off;
      if (ca[2:0] == 3'd4 || rem <= 4) begin L = 4; cmd = 8'h02; end
      else begin L = ((rem + 7) / 8) * 8; if (L > 240) L = 240; cmd = 8'h04; end
      if (w) cmd = cmd + 8'd1;
      ws = (L < 8) ? L : 8;
      hdr = w ? 5 : 9;
      if (t < ntx) begin
        ts = tx_start[t];
        chk(tx_len[t] == (w ? L + 6 : L + 9), "R4 transaction length", tx_len[t], w ? L + 6 : L + 9);
        chk(wlog[ts] == cmd, "R3 command byte", wlog[ts], cmd);
        chk({wlog[ts+1], wlog[ts+2], wlog[ts+3], wlog[ts+4]} == ca, "R2 address header",
            {wlog[ts+1], wlog[ts+2], wlog[ts+3], wlog[ts+4]}, ca);
        if (tx_len[t] == (w ? L + 6 : L + 9)) begin
          ok = 1; bad_i = 0;
          for (int j = 0; j < L; j++) begin
            w0 = (j / ws) * ws; ii = j % ws; si = w0 + ws - 1 - ii;
            if (w) begin
              eb = (si < rem) ? exp_buf[off + si] : 8'h00;
              if (ok && wlog[ts + hdr + j] != eb) begin ok = 0; bad_i = j; end
            end else if (si < rem) begin
              exp_buf[off + si] = rb(ca + 32'(j));
            end
          end
          if (w) begin
            chk(ok, "R5 write body order", wlog[ts + hdr + bad_i], bad_i);
            chk(wlog[ts + 5 + L] == 8'h00, "R6 trailing byte", wlog[ts + 5 + L], 0);
          end else begin
            chk({wlog[ts+5], wlog[ts+6], wlog[ts+7], wlog[ts+8]} == 32'h0, "R7 dummy bytes",
                {wlog[ts+5], wlog[ts+6], wlog[ts+7], wlog[ts+8]}, 0);
          end
        end
      end
      off += L; t++;
    end
    chk(ntx - t0 == t - t0, "R8 transaction count", ntx - t0, t - t0);
    if (poke) chk(ntx - t0 == t - t0, "R11 start while busy ignored", ntx - t0, t - t0);
    if (!w) begin
      ok = 1; bad_i = 0;
      for (int i = 0; i < 512; i++)
        if (ok && lbuf[i] != exp_buf[i]) begin ok = 0; bad_i = i; end
      chk(ok, "R5/R7 read buffer contents", lbuf[bad_i], exp_buf[bad_i]);
    end
  endtask

  initial begin
    int sd;
    logic [31:0] ra;
    int rl;
    bit rw;
    sd = int'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1 && sclk == 0, "R1 SPI idle in reset", {cs_n, sclk}, 2'b10);
    chk(busy == 0 && done == 0 && err == 0, "R1 status low", {busy, done, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1 && busy == 0, "R1 idle after reset", {cs_n, busy}, 2'b10);

    run_req(32'h0000_1000, 4, 1, 0);    // R3 single write
    run_req(32'h0000_1004, 16, 1, 0);   // R3 align-4 single, R6 zero-filled tail
    run_req(32'h0000_2000, 5, 1, 0);    // R6 burst 8 with fill
    run_req(32'h0000_3000, 12, 0, 0);   // R7 overshoot not written
    run_req(32'h0000_0010, 260, 0, 0);  // R4 cap at 240
    run_req(32'hFFFF_FFFC, 8, 1, 0);    // R8 address wrap
    run_req(32'h0000_0002, 8, 0, 0);    // R9 refusals
    run_req(32'h0000_0000, 6, 0, 0);
    run_req(32'h0000_0001, 8, 1, 0);
    run_req(32'h0000_0000, 6, 1, 0);    // R9 write length unconstrained
    run_req(32'h0000_0040, 0, 1, 0);    // R8 zero length
    run_req(32'h0000_4000, 40, 1, 1);   // R11 poke while busy

    for (int r = 0; r < 25 && !timeout; r++) begin
      rw = 1'($urandom);
      ra = $urandom;
      if ($urandom % 8 != 0) ra[1:0] = 2'b00;
      rl = int'($urandom % 49);
      if (!rw && ($urandom % 8 != 0)) rl = rl & ~3;
      run_req(ra, rl, rw, 0);
    end

    chk(gapviol == 0, "R10 chip-select gap", gapviol, 0);
    chk(sclkviol == 0, "R10 clock idle while deselected", sclkviol, 0);
    if (timeout) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cyc < WD + 5000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog hang actual=%0d expected<%0d", cyc, WD);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule